// File: doc/BRIEF.md
# Cache Maintenance Command Controller

This block owns the line state of a small direct-mapped write-back data cache (a tag, a valid bit, a dirty bit and one data word per line) and runs maintenance commands against it. A requester issues one command at a time through a valid/ready command port, together with an address operand. Dirty lines leave through a memory write port that uses its own valid/ready handshake. A one-cycle done pulse marks the end of each command.

There are four commands. Two act on a single line: flush, which writes the line back if it is dirty and then drops it, and clean, which writes the line back if it is dirty and keeps it resident. Two act on the whole cache: a discard that drops every line without writing any data back, and a writeback-discard that writes out every dirty line and then drops all lines. A line install port lets the normal cache datapath place lines into the array. That port only takes effect while the controller is idle.

Top module: `cmo_ctrl`

## Requirements
- R1: After reset, cmd_ready_o is 1, done_o and mem_wvalid_o are 0, and no line is valid. A whole-cache writeback-discard issued right after reset produces no memory write.
- R2: Opcode 0 (flush) on a hit to a dirty line issues exactly one memory write and leaves the line invalid. On a hit to a clean line it writes nothing and also leaves the line invalid. A later clean of the same address writes nothing.
- R3: Opcode 1 (clean) on a hit to a dirty line issues exactly one memory write and clears the dirty bit, so a repeated clean writes nothing.
- R4: A flush or clean whose line is invalid, or whose stored tag differs from the address tag, completes without any memory write.
- R5: Opcode 2 (discard all) never raises mem_wvalid_o. Dirty data is lost, so a following writeback-discard writes nothing.
- R6: Opcode 3 (writeback-discard all) writes every valid dirty line once, in ascending index order, and leaves no line valid.
- R7: A memory write holds mem_wvalid_o, mem_waddr_o and mem_wdata_o steady until mem_wready_i is 1. mem_waddr_o is {tag, index}, and mem_wdata_o is the full line word in one beat.
- R8: cmd_ready_o is low from the cycle after a command is accepted until the done pulse. done_o is high for exactly one cycle, and cmd_ready_o is high again in the cycle after it.
- R9: An install presented while a command is active is ignored. An install presented in the same cycle that a command is accepted is written first, so that command sees it.
- R10: An install while idle sets the line at the address index to valid, with the address tag, the given data and the given dirty bit. The address fields are: index = addr[4:2], tag = addr[12:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Controller idle and able to accept |
| cmd_op_i | input | 2 | 0 flush, 1 clean, 2 discard all, 3 writeback-discard all |
| cmd_addr_i | input | 13 | Address operand (ignored by whole-cache commands) |
| done_o | output | 1 | One-cycle end-of-command pulse |
| inst_valid_i | input | 1 | Line install strobe |
| inst_addr_i | input | 13 | Install address |
| inst_data_i | input | 32 | Install line data |
| inst_dirty_i | input | 1 | Install line as dirty |
| mem_wvalid_o | output | 1 | Memory write request |
| mem_wready_i | input | 1 | Memory write accepted |
| mem_waddr_o | output | 11 | Line address {tag, index} |
| mem_wdata_o | output | 32 | Line data |

## Verification
Two functions can fall in the same cycle: a line install and the acceptance of a command. The bench drives both at the same clock edge, as a dirty install followed by a flush of that address, and expects the flush to write back the newly installed data. It also drives an install one cycle after acceptance, while a writeback-discard walk is stalled by random memory backpressure. In that case it expects the walk and a follow-up writeback-discard to show no trace of the install.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {
    OP_FLUSH   = 2'd0,
    OP_CLEAN   = 2'd1,
    OP_DROPALL = 2'd2,
    OP_WBDROP  = 2'd3
  } cmo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_DONE
  } cmo_state_e;
endpackage

// File: rtl/cmo_line_store.sv
module cmo_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inst_we_i,
  input  logic [IDX_W-1:0]  inst_idx_i,
  input  logic [TAG_W-1:0]  inst_tag_i,
  input  logic [DATA_W-1:0] inst_data_i,
  input  logic              inst_dirty_i,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_clr_valid_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LINES = 1 << IDX_W;

  logic              valid_q [LINES];
  logic              dirty_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic ins_hit, upd_hit;
    assign ins_hit = inst_we_i && (inst_idx_i == IDX_W'(g));
    assign upd_hit = upd_en_i && (upd_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (ins_hit) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= inst_dirty_i;
      end else if (upd_hit) begin
        dirty_q[g] <= 1'b0;
        if (upd_clr_valid_i) valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (ins_hit) begin
        tag_q[g]  <= inst_tag_i;
        data_q[g] <= inst_data_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inst_we_i && upd_en_i)); // R9
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
  import cmo_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  output logic                    cmd_ready_o,
  input  logic [1:0]              cmd_op_i,
  input  logic [IDX_W-1:0]        cmd_idx_i,
  input  logic [TAG_W-1:0]        cmd_tag_i,
  output logic                    done_o,
  output logic [IDX_W-1:0]        rd_idx_o,
  input  logic                    rd_valid_i,
  input  logic                    rd_dirty_i,
  input  logic [TAG_W-1:0]        rd_tag_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  output logic                    upd_en_o,
  output logic [IDX_W-1:0]        upd_idx_o,
  output logic                    upd_clr_valid_o,
  output logic                    mem_wvalid_o,
  input  logic                    mem_wready_i,
  output logic [TAG_W+IDX_W-1:0]  mem_waddr_o,
  output logic [DATA_W-1:0]       mem_wdata_o
);
  cmo_state_e      state_q, state_d;
  cmo_op_e         op_q, cmd_op;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TAG_W-1:0] tag_q;
  logic hit, whole, last, dirty_line;

  assign cmd_op     = cmo_op_e'(cmd_op_i);
  assign hit        = rd_valid_i && (rd_tag_i == tag_q);
  assign whole      = (op_q == OP_DROPALL) || (op_q == OP_WBDROP);
  assign last       = &idx_q;
  assign dirty_line = rd_valid_i && rd_dirty_i;

  always_comb begin
    state_d         = state_q;
    idx_d           = idx_q;
    upd_en_o        = 1'b0;
    upd_clr_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) begin
        state_d = ST_LOOK;
        idx_d   = (cmd_op == OP_DROPALL || cmd_op == OP_WBDROP) ? '0 : cmd_idx_i;
      end
      ST_LOOK: unique case (op_q)
        OP_FLUSH: if (hit && rd_dirty_i) state_d = ST_WB;
                  else begin
                    upd_en_o = hit; upd_clr_valid_o = 1'b1; state_d = ST_DONE;
                  end
        OP_CLEAN: state_d = (hit && rd_dirty_i) ? ST_WB : ST_DONE;
        OP_DROPALL: begin
          upd_en_o = 1'b1; upd_clr_valid_o = 1'b1;
          if (last) state_d = ST_DONE; else idx_d = idx_q + 1'b1;
        end
        OP_WBDROP: if (dirty_line) state_d = ST_WB;
                   else begin
                     upd_en_o = 1'b1; upd_clr_valid_o = 1'b1;
                     if (last) state_d = ST_DONE; else idx_d = idx_q + 1'b1;
                   end
        default: state_d = ST_DONE;
      endcase
      ST_WB: if (mem_wready_i) begin
        upd_en_o        = 1'b1;
        upd_clr_valid_o = (op_q != OP_CLEAN);
        if (whole && !last) begin
          idx_d = idx_q + 1'b1; state_d = ST_LOOK;
        end else state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_FLUSH;
      idx_q   <= '0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (state_q == ST_IDLE && cmd_valid_i) begin
        op_q  <= cmd_op;
        tag_q <= cmd_tag_i;
      end
    end
  end

  assign cmd_ready_o  = (state_q == ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign rd_idx_o     = idx_q;
  assign upd_idx_o    = idx_q;
  assign mem_wvalid_o = (state_q == ST_WB);
  assign mem_waddr_o  = {rd_tag_i, idx_q};
  assign mem_wdata_o  = rd_data_i;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wvalid_o && !mem_wready_i |=> mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && cmd_ready_o); // R8
  AST_DROP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_DROPALL) && !cmd_ready_o |-> !mem_wvalid_o); // R5
endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32,
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W,
  localparam int LA_W   = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              done_o,
  input  logic              inst_valid_i,
  input  logic [ADDR_W-1:0] inst_addr_i,
  input  logic [DATA_W-1:0] inst_data_i,
  input  logic              inst_dirty_i,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [LA_W-1:0]   mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              inst_we, upd_en, upd_clr_valid;
  logic [IDX_W-1:0]  rd_idx, upd_idx;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;

  // installs only land while idle; a same-edge command then sees them
  assign inst_we = inst_valid_i && cmd_ready_o;

  cmo_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .inst_we_i      (inst_we),
    .inst_idx_i     (inst_addr_i[OFF_W +: IDX_W]),
    .inst_tag_i     (inst_addr_i[ADDR_W-1 -: TAG_W]),
    .inst_data_i    (inst_data_i),
    .inst_dirty_i   (inst_dirty_i),
    .upd_en_i       (upd_en),
    .upd_idx_i      (upd_idx),
    .upd_clr_valid_i(upd_clr_valid),
    .rd_idx_i       (rd_idx),
    .rd_valid_o     (rd_valid),
    .rd_dirty_o     (rd_dirty),
    .rd_tag_o       (rd_tag),
    .rd_data_o      (rd_data)
  );

  cmo_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_op_i,
    .cmd_idx_i      (cmd_addr_i[OFF_W +: IDX_W]),
    .cmd_tag_i      (cmd_addr_i[ADDR_W-1 -: TAG_W]),
    .done_o,
    .rd_idx_o       (rd_idx),
    .rd_valid_i     (rd_valid),
    .rd_dirty_i     (rd_dirty),
    .rd_tag_i       (rd_tag),
    .rd_data_i      (rd_data),
    .upd_en_o       (upd_en),
    .upd_idx_o      (upd_idx),
    .upd_clr_valid_o(upd_clr_valid),
    .mem_wvalid_o, .mem_wready_i, .mem_waddr_o, .mem_wdata_o
  );

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wvalid_o |-> rd_valid && rd_dirty); // R6
endmodule

// File: tb/cmo_ctrl_bench.sv
module cmo_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 0;
  logic [1:0]  cmd_op_i = 0;
  logic [12:0] cmd_addr_i = 0;
  logic        inst_valid_i = 0;
  logic [12:0] inst_addr_i = 0;
  logic [31:0] inst_data_i = 0;
  logic        inst_dirty_i = 0;
  logic        mem_wready_i = 0;
  logic        cmd_ready_o, done_o, mem_wvalid_o;
  logic [10:0] mem_waddr_o;
  logic [31:0] mem_wdata_o;

  int total = 0, bad = 0;
  int cyc = 0;

  logic        m_valid [8];
  logic        m_dirty [8];
  logic [7:0]  m_tag   [8];
  logic [31:0] m_data  [8];
  int          exp_n;
  logic [10:0] exp_a [8];
  logic [31:0] exp_d [8];

  always #5 clk = ~clk;

  cmo_ctrl u_cmo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_addr_i, .done_o,
    .inst_valid_i, .inst_addr_i, .inst_data_i, .inst_dirty_i,
    .mem_wvalid_o, .mem_wready_i, .mem_waddr_o, .mem_wdata_o
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void mdl_install(input logic [12:0] a, input logic [31:0] d, input logic dt);
    m_valid[a[4:2]] = 1'b1; m_dirty[a[4:2]] = dt;
    m_tag[a[4:2]] = a[12:5]; m_data[a[4:2]] = d;
  endfunction

  function automatic void mdl_cmd(input logic [1:0] op, input logic [12:0] a);
    int i = int'(a[4:2]);
    bit h = m_valid[i] && (m_tag[i] == a[12:5]);
    exp_n = 0;
    case (op)
      2'd0: begin
        if (h && m_dirty[i]) begin exp_a[0] = {m_tag[i], a[4:2]}; exp_d[0] = m_data[i]; exp_n = 1; end
        if (h) begin m_valid[i] = 0; m_dirty[i] = 0; end
      end
      2'd1: if (h && m_dirty[i]) begin
        exp_a[0] = {m_tag[i], a[4:2]}; exp_d[0] = m_data[i]; exp_n = 1; m_dirty[i] = 0;
      end
      2'd2: for (int k = 0; k < 8; k++) begin m_valid[k] = 0; m_dirty[k] = 0; end
      default: for (int k = 0; k < 8; k++) begin
        if (m_valid[k] && m_dirty[k]) begin
          exp_a[exp_n] = {m_tag[k], 3'(k)}; exp_d[exp_n] = m_data[k]; exp_n++;
        end
        m_valid[k] = 0; m_dirty[k] = 0;
      end
    endcase
  endfunction

  task automatic install(input logic [12:0] a, input logic [31:0] d, input logic dt);
    @(negedge clk);
    inst_valid_i = 1; inst_addr_i = a; inst_data_i = d; inst_dirty_i = dt;
    @(negedge clk);
    inst_valid_i = 0;
    mdl_install(a, d, dt);
  endtask

  // mode 0 plain, 1 install at accept edge, 2 install one cycle into the command
  task automatic run_cmd(input logic [1:0] op, input logic [12:0] a, input int mode,
                         input logic [12:0] ia, input logic [31:0] id, input string req);
    int got = 0;
    int n = 0;
    if (mode == 1) mdl_install(ia, id, 1'b1);
    mdl_cmd(op, a);
    @(negedge clk);
    chk(cmd_ready_o === 1'b1, "R8", "ready before accept", 64'(cmd_ready_o), 1);
    cmd_valid_i = 1; cmd_op_i = op; cmd_addr_i = a;
    if (mode == 1) begin inst_valid_i = 1; inst_addr_i = ia; inst_data_i = id; inst_dirty_i = 1; end
    @(negedge clk);
    cmd_valid_i = 0; inst_valid_i = 0;
    if (mode == 2) begin inst_valid_i = 1; inst_addr_i = ia; inst_data_i = id; inst_dirty_i = 1; end
    while (done_o !== 1'b1 && n < 2000) begin
      if (n > 0) inst_valid_i = 0;
      if (cmd_ready_o !== 1'b0)
        chk(0, "R8", "ready while busy", 64'(cmd_ready_o), 0);
      mem_wready_i = 0;
      if (mem_wvalid_o === 1'b1 && ($urandom % 3) != 0) begin
        mem_wready_i = 1;
        if (got < exp_n)
          chk(mem_waddr_o == exp_a[got] && mem_wdata_o == exp_d[got], req, "write beat",
              {21'd0, mem_waddr_o, mem_wdata_o}, {21'd0, exp_a[got], exp_d[got]});
        else
          chk(0, req, "unexpected write", {21'd0, mem_waddr_o, mem_wdata_o}, 0);
        got++;
      end
      @(negedge clk);
      n++;
    end
    inst_valid_i = 0; mem_wready_i = 0;
    chk(done_o === 1'b1, "R8", "done seen", 64'(done_o), 1);
    chk(mem_wvalid_o === 1'b0, req, "no write at done", 64'(mem_wvalid_o), 0);
    chk(got == exp_n, req, "write count", 64'(got), 64'(exp_n));
    @(negedge clk);
    chk(done_o === 1'b0 && cmd_ready_o === 1'b1, "R8", "done single, ready back",
        {62'd0, done_o, cmd_ready_o}, 64'b01);
  endtask

  function automatic logic [12:0] mk(input logic [7:0] t, input logic [2:0] i);
    return {t, i, 2'b00};
  endfunction

  initial begin
    void'($urandom(32'h5eed_cafe));
    for (int k = 0; k < 8; k++) begin m_valid[k] = 0; m_dirty[k] = 0; m_tag[k] = 0; m_data[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready_o === 1 && done_o === 0 && mem_wvalid_o === 0, "R1", "reset outputs",
        {61'd0, cmd_ready_o, done_o, mem_wvalid_o}, 64'b100);
    run_cmd(2'd3, 0, 0, 0, 0, "R1");

    // R10 / R2: install dirty then flush hit
    install(mk(8'h5A, 3), 32'hDEAD_0003, 1);
    run_cmd(2'd0, mk(8'h5A, 3), 0, 0, 0, "R2");
    run_cmd(2'd1, mk(8'h5A, 3), 0, 0, 0, "R2");
    // R2: flush of a clean hit writes nothing and drops the line
    install(mk(8'h5C, 2), 32'hC1EA_0002, 0);
    run_cmd(2'd0, mk(8'h5C, 2), 0, 0, 0, "R2");
    // R4 miss on tag, R3 clean keeps line clean
    install(mk(8'h33, 5), 32'h1234_5678, 1);
    run_cmd(2'd0, mk(8'h34, 5), 0, 0, 0, "R4");
    run_cmd(2'd1, mk(8'h55, 7), 0, 0, 0, "R4");
    run_cmd(2'd1, mk(8'h33, 5), 0, 0, 0, "R3");
    run_cmd(2'd1, mk(8'h33, 5), 0, 0, 0, "R3");
    // R5 discard loses dirty data
    install(mk(8'h01, 0), 32'hA0, 1);
    install(mk(8'h02, 7), 32'hA7, 1);
    run_cmd(2'd2, 0, 0, 0, 0, "R5");
    run_cmd(2'd3, 0, 0, 0, 0, "R5");
    // R6 ascending walk, R9 install while busy ignored
    install(mk(8'h66, 6), 32'h6666, 1);
    install(mk(8'h11, 1), 32'h1111, 1);
    install(mk(8'h44, 4), 32'h4444, 1);
    install(mk(8'h22, 2), 32'h2222, 0);
    run_cmd(2'd3, 0, 2, mk(8'h77, 0), 32'h7777, "R6");
    run_cmd(2'd3, 0, 0, 0, 0, "R9");
    // R9 install at the accept edge is seen by that command
    run_cmd(2'd0, mk(8'h9A, 3), 1, mk(8'h9A, 3), 32'hFEED_0009, "R9");

    for (int it = 0; it < 120; it++) begin
      logic [12:0] a;
      logic [1:0]  op;
      a = {(($urandom % 2) != 0) ? 8'h11 : 8'h22, 3'($urandom), 2'($urandom)};
      if (($urandom % 2) != 0) install(a, $urandom, 1'($urandom));
      a = {(($urandom % 2) != 0) ? 8'h11 : 8'h22, 3'($urandom), 2'($urandom)};
      op = (($urandom % 8) == 0) ? 2'd2 : (($urandom % 5) == 0) ? 2'd3 : 2'($urandom % 2);
      run_cmd(op, a, int'($urandom % 3), a ^ 13'h0020, $urandom, "R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule